// File: doc/BRIEF.md
# Frame Buffer Handle Allocator

This block keeps the pool of frame control handles for a shared-memory packet switch. Every arriving frame asks for a handle on behalf of its source port. The block hands out the oldest free handle in the same cycle, unless the port's share of the pool forbids it. When the frame has left the switch, the handle comes back on the release port. Each port owns a small guaranteed reserve. Beyond that reserve a port draws on a shared pool, and a hard per-port ceiling caps how much it can hold in total.

An accepted unicast handle can be linked onto a transmit queue chosen by destination port and class. The queue is a linked list threaded through the same next-pointer store that the free list uses. A dequeue pops the head of a queue. The handle stays held until it is released. A free-running timestamp marks when each handle was allocated. A background scan checks one handle per cycle, and when aging is strapped on it reclaims a held, unqueued handle that has been kept longer than the programmed limit. Each such reclaim is counted.

Top module: `fbh_alloc`

## Requirements
- R1: After reset all NUM_HANDLES handles are free, `free_count` equals NUM_HANDLES, every queue is empty and `drop_cnt` is zero. The first grants return handles 0, 1, 2 in ascending order.
- R2: A request that is accepted sees `alloc_gnt` high in the same cycle, with `alloc_handle` set to the head of the free list. Released handles go to the tail, so they are reused in the order they came back.
- R3: A port holding fewer than RESERVE handles is always served while a handle is free. A port at or above RESERVE is served only if the total held above reserve, summed over all ports, is below NUM_HANDLES minus NUM_PORTS*RESERVE. With no free handle, nothing is granted.
- R4: A port already holding PORT_LIMIT handles is refused.
- R5: A release takes effect only for a handle that is held and not queued. A release of a free or queued handle is ignored and leaves `free_count` unchanged.
- R6: Allocation and release in the same cycle are both carried out, with admission judged on the state before that cycle. The net change of `free_count` is zero.
- R7: A link appends a held, unqueued handle to queue (`link_port`, `link_cls`). Other links are ignored. If the same handle is released in the same cycle, the release wins.
- R8: `deq_vld` is high when queue (`deq_port`, `deq_cls`) is non-empty, and `deq_handle` shows its head. A dequeue advances the head and leaves the handle held. A link and a dequeue on the same queue in the same cycle are both carried out.
- R9: A free-running timestamp starts at 0 after reset and counts every cycle. The scan index starts at 0, visits handles in ascending order one per cycle and wraps. It pauses in any cycle where `rel_req` or `link_req` is high. The scanned handle is reclaimed (`age_drop` high, `age_handle` = index) when aging is enabled, the handle is held and not queued, and (now − alloc stamp) mod 2^TS_W exceeds `age_limit`. Each reclaim frees the handle and raises `drop_cnt` by one.
- R10: With `age_en` low, no handle is ever reclaimed by aging.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| age_en | input | 1 | Static strap enabling aging |
| age_limit | input | TS_W | Aging timeout in cycles |
| alloc_req | input | 1 | Request a handle |
| alloc_port | input | log2(NUM_PORTS) | Source port of the request |
| alloc_gnt | output | 1 | Request accepted this cycle |
| alloc_handle | output | log2(NUM_HANDLES) | Handle granted |
| rel_req | input | 1 | Return a handle |
| rel_handle | input | log2(NUM_HANDLES) | Handle returned |
| link_req | input | 1 | Append a handle to a transmit queue |
| link_handle | input | log2(NUM_HANDLES) | Handle to append |
| link_port | input | log2(NUM_PORTS) | Destination port |
| link_cls | input | log2(NUM_CLASSES) | Traffic class |
| deq_req | input | 1 | Pop selected queue |
| deq_port | input | log2(NUM_PORTS) | Queue port selector |
| deq_cls | input | log2(NUM_CLASSES) | Queue class selector |
| deq_vld | output | 1 | Selected queue non-empty |
| deq_handle | output | log2(NUM_HANDLES) | Head of selected queue |
| age_drop | output | 1 | Scanned handle reclaimed by aging |
| age_handle | output | log2(NUM_HANDLES) | Handle under scan |
| free_count | output | log2(NUM_HANDLES+1) | Free handles |
| drop_cnt | output | DROP_W | Aging reclaim count |

## Verification
Allocation can collide with a return of a handle to the free list. That return comes either from an explicit release or from an aging reclaim, and a collision near an empty list rewrites the free-list head. The bench drives grants and releases in the same cycle, once with one free handle left and again through a long random mix. It then checks the grant, the granted handle and `free_count` on every cycle against a queue-based model whose admission reads the state from before the cycle. A link and a dequeue on a single-entry queue are also paired in one cycle. Afterwards the head must move to the new handle.

// File: rtl/fbh_pkg.sv
package fbh_pkg;

    typedef enum logic [1:0] {
        HS_FREE   = 2'd0,
        HS_HELD   = 2'd1,
        HS_QUEUED = 2'd2
    } hstate_e;

    // index width that stays at least one bit
    function automatic int idx_w(input int n);
        return (n > 1) ? $clog2(n) : 1;
    endfunction

endpackage

// File: rtl/fbh_stamp.sv
module fbh_stamp #(
    parameter int TS_W = 16
) (
    input  logic            clk,
    input  logic            rst_n,
    output logic [TS_W-1:0] now
);
    logic [TS_W-1:0] now_d, now_q;

    always_comb begin
        now_d = now_q + TS_W'(1);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) now_q <= '0;
        else        now_q <= now_d;
    end

    assign now = now_q;
endmodule

// File: rtl/fbh_admit.sv
module fbh_admit #(
    parameter int NP     = 4,
    parameter int RSV    = 2,
    parameter int LIM    = 6,
    parameter int SHARED = 8,
    parameter int UW     = 3,
    parameter int PW     = 2
) (
    input  logic [NP-1:0][UW-1:0] used,
    input  logic [PW-1:0]         port,
    output logic                  ok
);
    localparam int SW = $clog2(NP * LIM + 1);

    logic [SW-1:0] over_sum;
    logic [UW-1:0] mine;

    always_comb begin
        over_sum = '0;
        for (int p = 0; p < NP; p++) begin
            if (int'(used[p]) > RSV)
                over_sum = over_sum + SW'(int'(used[p]) - RSV);
        end
        mine = used[port];
        ok   = (int'(mine) < LIM) &&
               ((int'(mine) < RSV) || (int'(over_sum) < SHARED));
    end
endmodule

// File: rtl/fbh_alloc.sv
module fbh_alloc
    import fbh_pkg::*;
#(
    parameter int NUM_HANDLES = 16,
    parameter int NUM_PORTS   = 4,
    parameter int NUM_CLASSES = 2,
    parameter int RESERVE     = 2,
    parameter int PORT_LIMIT  = 6,
    parameter int TS_W        = 16,
    parameter int DROP_W      = 16
) (
    input  logic                                clk,
    input  logic                                rst_n,
    input  logic                                age_en,
    input  logic [TS_W-1:0]                     age_limit,
    input  logic                                alloc_req,
    input  logic [idx_w(NUM_PORTS)-1:0]         alloc_port,
    output logic                                alloc_gnt,
    output logic [idx_w(NUM_HANDLES)-1:0]       alloc_handle,
    input  logic                                rel_req,
    input  logic [idx_w(NUM_HANDLES)-1:0]       rel_handle,
    input  logic                                link_req,
    input  logic [idx_w(NUM_HANDLES)-1:0]       link_handle,
    input  logic [idx_w(NUM_PORTS)-1:0]         link_port,
    input  logic [idx_w(NUM_CLASSES)-1:0]       link_cls,
    input  logic                                deq_req,
    input  logic [idx_w(NUM_PORTS)-1:0]         deq_port,
    input  logic [idx_w(NUM_CLASSES)-1:0]       deq_cls,
    output logic                                deq_vld,
    output logic [idx_w(NUM_HANDLES)-1:0]       deq_handle,
    output logic                                age_drop,
    output logic [idx_w(NUM_HANDLES)-1:0]       age_handle,
    output logic [$clog2(NUM_HANDLES+1)-1:0]    free_count,
    output logic [DROP_W-1:0]                   drop_cnt
);
    localparam int HW     = idx_w(NUM_HANDLES);
    localparam int PW     = idx_w(NUM_PORTS);
    localparam int KW     = idx_w(NUM_CLASSES);
    localparam int NQ     = NUM_PORTS * NUM_CLASSES;
    localparam int QW     = idx_w(NQ);
    localparam int CW     = $clog2(NUM_HANDLES + 1);
    localparam int UW     = $clog2(PORT_LIMIT + 1);
    localparam int SHARED = NUM_HANDLES - NUM_PORTS * RESERVE;

    typedef struct packed {
        logic [NUM_HANDLES-1:0][HW-1:0]   nxt;
        logic [NUM_HANDLES-1:0][1:0]      hst;
        logic [NUM_HANDLES-1:0][PW-1:0]   owner;
        logic [NUM_HANDLES-1:0][TS_W-1:0] ts;
        logic [HW-1:0]                    fhead;
        logic [HW-1:0]                    ftail;
        logic [CW-1:0]                    fcnt;
        logic [NUM_PORTS-1:0][UW-1:0]     used;
        logic [NQ-1:0][HW-1:0]            qhead;
        logic [NQ-1:0][HW-1:0]            qtail;
        logic [NQ-1:0][CW-1:0]            qcnt;
        logic [HW-1:0]                    scan;
        logic [DROP_W-1:0]                dcnt;
    } state_t;

    state_t s_d, s_q;

    logic [TS_W-1:0] now;
    logic            adm_ok;
    logic            rel_ok;
    logic            link_ok;
    logic            deq_ok;
    logic            push;
    logic [HW-1:0]   push_h;
    logic [TS_W-1:0] age_val;
    logic [QW-1:0]   lqi;
    logic [QW-1:0]   dqi;

    fbh_stamp #(.TS_W(TS_W)) u_stamp (
        .clk   (clk),
        .rst_n (rst_n),
        .now   (now)
    );

    fbh_admit #(
        .NP     (NUM_PORTS),
        .RSV    (RESERVE),
        .LIM    (PORT_LIMIT),
        .SHARED (SHARED),
        .UW     (UW),
        .PW     (PW)
    ) u_admit (
        .used (s_q.used),
        .port (alloc_port),
        .ok   (adm_ok)
    );

    always_comb begin
        s_d = s_q;

        lqi = QW'(int'(link_port) * NUM_CLASSES + int'(link_cls));
        dqi = QW'(int'(deq_port) * NUM_CLASSES + int'(deq_cls));

        alloc_gnt = alloc_req && adm_ok && (s_q.fcnt != '0);
        rel_ok    = rel_req && (s_q.hst[rel_handle] == HS_HELD);
        age_val   = now - s_q.ts[s_q.scan];
        age_drop  = age_en && !rel_req && !link_req &&
                    (s_q.hst[s_q.scan] == HS_HELD) && (age_val > age_limit);
        push      = rel_ok || age_drop;
        push_h    = rel_ok ? rel_handle : s_q.scan;
        link_ok   = link_req && (s_q.hst[link_handle] == HS_HELD) &&
                    !(rel_ok && (rel_handle == link_handle));
        deq_vld   = (s_q.qcnt[dqi] != '0);
        deq_ok    = deq_req && deq_vld;

        // transmit queue pop
        if (deq_ok) begin
            s_d.hst[s_q.qhead[dqi]] = HS_HELD;
            s_d.qhead[dqi]          = s_q.nxt[s_q.qhead[dqi]];
        end

        // transmit queue append
        if (link_ok) begin
            s_d.hst[link_handle] = HS_QUEUED;
            s_d.qtail[lqi]       = link_handle;
            if ((s_q.qcnt[lqi] == '0) ||
                (deq_ok && (dqi == lqi) && (s_q.qcnt[lqi] == CW'(1))))
                s_d.qhead[lqi] = link_handle;
            else
                s_d.nxt[s_q.qtail[lqi]] = link_handle;
        end

        for (int q = 0; q < NQ; q++) begin
            s_d.qcnt[q] = s_q.qcnt[q]
                        + CW'(link_ok && (lqi == QW'(q)))
                        - CW'(deq_ok && (dqi == QW'(q)));
        end

        // free list pop
        if (alloc_gnt) begin
            s_d.hst[s_q.fhead]   = HS_HELD;
            s_d.owner[s_q.fhead] = alloc_port;
            s_d.ts[s_q.fhead]    = now;
            s_d.fhead            = s_q.nxt[s_q.fhead];
        end

        // free list push
        if (push) begin
            s_d.hst[push_h] = HS_FREE;
            s_d.ftail       = push_h;
            if ((s_q.fcnt == '0) || (alloc_gnt && (s_q.fcnt == CW'(1))))
                s_d.fhead = push_h;
            else
                s_d.nxt[s_q.ftail] = push_h;
        end

        s_d.fcnt = s_q.fcnt + CW'(push) - CW'(alloc_gnt);

        for (int p = 0; p < NUM_PORTS; p++) begin
            s_d.used[p] = s_q.used[p]
                        + UW'(alloc_gnt && (alloc_port == PW'(p)))
                        - UW'(push && (s_q.owner[push_h] == PW'(p)));
        end

        // aging scan
        if (!rel_req && !link_req)
            s_d.scan = (int'(s_q.scan) == NUM_HANDLES - 1) ? '0 : s_q.scan + HW'(1);
        if (age_drop)
            s_d.dcnt = s_q.dcnt + DROP_W'(1);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q       <= '0;
            s_q.ftail <= HW'(NUM_HANDLES - 1);
            s_q.fcnt  <= CW'(NUM_HANDLES);
            for (int i = 0; i < NUM_HANDLES; i++)
                s_q.nxt[i] <= HW'(i + 1);
        end else begin
            s_q <= s_d;
        end
    end

    assign alloc_handle = s_q.fhead;
    assign deq_handle   = s_q.qhead[dqi];
    assign age_handle   = s_q.scan;
    assign free_count   = s_q.fcnt;
    assign drop_cnt     = s_q.dcnt;

endmodule

// File: rtl/fbh_alloc_chk.sv
module fbh_alloc_chk #(
    parameter int NUM_HANDLES = 16,
    parameter int DROP_W      = 16
) (
    input logic                             clk,
    input logic                             rst_n,
    input logic                             age_en,
    input logic                             alloc_gnt,
    input logic                             rel_ok,
    input logic                             rel_req,
    input logic                             link_req,
    input logic                             age_drop,
    input logic [$clog2(NUM_HANDLES+1)-1:0] free_count,
    input logic [DROP_W-1:0]                drop_cnt
);
    localparam int CW = $clog2(NUM_HANDLES + 1);

    assert_bound_R1: assert property (@(posedge clk) disable iff (!rst_n)
        int'(free_count) <= NUM_HANDLES);

    assert_empty_no_grant_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (free_count == '0) |-> !alloc_gnt);

    assert_pop_count_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (alloc_gnt && !rel_ok && !age_drop) |=>
        (free_count + CW'(1) == $past(free_count)));

    assert_pair_balance_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (alloc_gnt && (rel_ok || age_drop)) |=> $stable(free_count));

    assert_age_pause_R9: assert property (@(posedge clk) disable iff (!rst_n)
        age_drop |-> (!rel_req && !link_req));

    assert_drop_count_R9: assert property (@(posedge clk) disable iff (!rst_n)
        age_drop |=> (drop_cnt == $past(drop_cnt) + DROP_W'(1)));

    assert_age_gate_R10: assert property (@(posedge clk) disable iff (!rst_n)
        age_drop |-> age_en);
endmodule

bind fbh_alloc fbh_alloc_chk #(
    .NUM_HANDLES (NUM_HANDLES),
    .DROP_W      (DROP_W)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .age_en     (age_en),
    .alloc_gnt  (alloc_gnt),
    .rel_ok     (rel_ok),
    .rel_req    (rel_req),
    .link_req   (link_req),
    .age_drop   (age_drop),
    .free_count (free_count),
    .drop_cnt   (drop_cnt)
);

// File: tb/fbh_alloc_bench.sv
module fbh_alloc_bench;
    localparam int CLK_PERIOD = 10;
    localparam int NH  = 16;
    localparam int NP  = 4;
    localparam int NC  = 2;
    localparam int RSV = 2;
    localparam int LIM = 6;
    localparam int NQ  = NP * NC;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        age_en = 1'b0;
    logic [15:0] age_limit = '0;
    logic        alloc_req = 1'b0;
    logic [1:0]  alloc_port = '0;
    logic        alloc_gnt;
    logic [3:0]  alloc_handle;
    logic        rel_req = 1'b0;
    logic [3:0]  rel_handle = '0;
    logic        link_req = 1'b0;
    logic [3:0]  link_handle = '0;
    logic [1:0]  link_port = '0;
    logic        link_cls = 1'b0;
    logic        deq_req = 1'b0;
    logic [1:0]  deq_port = '0;
    logic        deq_cls = 1'b0;
    logic        deq_vld;
    logic [3:0]  deq_handle;
    logic        age_drop;
    logic [3:0]  age_handle;
    logic [4:0]  free_count;
    logic [15:0] drop_cnt;

    always #(CLK_PERIOD/2) clk = ~clk;

    fbh_alloc u_fbh_alloc (
        .clk(clk), .rst_n(rst_n), .age_en(age_en), .age_limit(age_limit),
        .alloc_req(alloc_req), .alloc_port(alloc_port), .alloc_gnt(alloc_gnt),
        .alloc_handle(alloc_handle), .rel_req(rel_req), .rel_handle(rel_handle),
        .link_req(link_req), .link_handle(link_handle), .link_port(link_port),
        .link_cls(link_cls), .deq_req(deq_req), .deq_port(deq_port),
        .deq_cls(deq_cls), .deq_vld(deq_vld), .deq_handle(deq_handle),
        .age_drop(age_drop), .age_handle(age_handle), .free_count(free_count),
        .drop_cnt(drop_cnt)
    );

    int checks = 0;
    int failures = 0;
    bit done = 0;

    // behavioural model
    int fl[$];
    int tq[NQ][$];
    int mh[NH];     // 0 free, 1 held, 2 queued
    int mown[NH];
    int mts[NH];
    int mused[NP];
    int scan, now, dcnt;
    int phs[NP][$];

    // values seen in the last cycle
    bit g_gnt, g_dvld, g_age;
    int g_h, g_dh, g_fc, g_dc;

    task automatic chk(input bit ok, input string tag, input int got, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s got=%0d exp=%0d", tag, got, exp);
        end
    endtask

    function automatic bit m_adm(input int p);
        int sh = 0;
        for (int i = 0; i < NP; i++) if (mused[i] > RSV) sh += mused[i] - RSV;
        return (mused[p] < LIM) && ((mused[p] < RSV) || (sh < NH - NP*RSV));
    endfunction

    task automatic cyc(input bit ar, input int ap, input bit rr, input int rh,
                       input bit lr, input int lh, input int lp, input int lc,
                       input bit dr, input int dp, input int dc);
        bit e_gnt, e_rel, e_age, e_link, e_dvld;
        int dq, lq, ph, h;
        alloc_req = ar; alloc_port = 2'(ap);
        rel_req = rr;   rel_handle = 4'(rh);
        link_req = lr;  link_handle = 4'(lh); link_port = 2'(lp); link_cls = 1'(lc);
        deq_req = dr;   deq_port = 2'(dp); deq_cls = 1'(dc);
        #1;
        dq = dp * NC + dc;
        lq = lp * NC + lc;
        e_gnt  = ar && (fl.size() > 0) && m_adm(ap);
        e_rel  = rr && (mh[rh] == 1);
        e_age  = age_en && !rr && !lr && (mh[scan] == 1) &&
                 (((now - mts[scan]) & 16'hFFFF) > int'(age_limit));
        e_link = lr && (mh[lh] == 1) && !(e_rel && rh == lh);
        e_dvld = tq[dq].size() > 0;

        g_gnt = alloc_gnt; g_h = alloc_handle; g_dvld = deq_vld; g_dh = deq_handle;
        g_age = age_drop; g_fc = free_count; g_dc = drop_cnt;

        chk(alloc_gnt == e_gnt, "R2/R3 alloc_gnt", alloc_gnt, e_gnt);
        if (e_gnt) chk(alloc_handle == 4'(fl[0]), "R2 alloc_handle", alloc_handle, fl[0]);
        chk(deq_vld == e_dvld, "R8 deq_vld", deq_vld, e_dvld);
        if (e_dvld) chk(deq_handle == 4'(tq[dq][0]), "R8 deq_handle", deq_handle, tq[dq][0]);
        chk(age_drop == e_age, "R9 age_drop", age_drop, e_age);
        chk(age_handle == 4'(scan), "R9 age_handle", age_handle, scan);
        chk(int'(free_count) == fl.size(), "R6 free_count", free_count, fl.size());
        chk(int'(drop_cnt) == dcnt, "R9 drop_cnt", drop_cnt, dcnt);

        if (dr && e_dvld) begin
            h = tq[dq].pop_front();
            mh[h] = 1;
        end
        if (e_link) begin
            mh[lh] = 2;
            tq[lq].push_back(lh);
        end
        if (e_gnt) begin
            h = fl.pop_front();
            mh[h] = 1; mown[h] = ap; mts[h] = now; mused[ap]++;
            phs[ap].push_back(h);
        end
        if (e_rel || e_age) begin
            ph = e_rel ? rh : scan;
            mh[ph] = 0;
            mused[mown[ph]]--;
            fl.push_back(ph);
        end
        if (e_age) dcnt++;
        if (!rr && !lr) scan = (scan + 1) % NH;
        now++;
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic idle();                 cyc(0,0,0,0,0,0,0,0,0,0,0); endtask
    task automatic peek(input int p, input int c); cyc(0,0,0,0,0,0,0,0,0,p,c); endtask
    task automatic do_alloc(input int p);  cyc(1,p,0,0,0,0,0,0,0,0,0); endtask
    task automatic do_rel(input int h);    cyc(0,0,1,h,0,0,0,0,0,0,0); endtask
    task automatic do_link(input int h, input int p, input int c); cyc(0,0,0,0,1,h,p,c,0,0,0); endtask
    task automatic do_deq(input int p, input int c); cyc(0,0,0,0,0,0,0,0,1,p,c); endtask

    task automatic summary();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL R1 watchdog got=0 exp=1");
            summary();
            $finish;
        end
    end

    initial begin
        int cnt, ha, hb, t0, seen;
        for (int i = 0; i < NH; i++) begin
            fl.push_back(i); mh[i] = 0; mown[i] = 0; mts[i] = 0;
        end
        for (int p = 0; p < NP; p++) mused[p] = 0;
        scan = 0; now = 0; dcnt = 0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;

        // reset state
        idle();
        chk(g_fc == NH, "R1 reset free_count", g_fc, NH);
        chk(g_dvld == 0, "R1 reset queue empty", g_dvld, 0);
        chk(g_dc == 0, "R1 reset drop_cnt", g_dc, 0);
        for (int i = 0; i < 3; i++) begin
            do_alloc(0);
            chk(g_gnt && g_h == i, "R1 ascending grant", g_h, i);
        end

        // ignored release and links
        do_rel(9);
        idle();
        chk(g_fc == 13, "R5 release of free ignored", g_fc, 13);
        do_link(2, 1, 1);
        peek(1, 1);
        chk(g_dvld && g_dh == 2, "R7 link appended", g_dh, 2);
        do_rel(2);
        idle();
        chk(g_fc == 13, "R5 release of queued ignored", g_fc, 13);
        do_link(9, 0, 0);
        peek(0, 0);
        chk(g_dvld == 0, "R7 link of free ignored", g_dvld, 0);
        do_deq(1, 1);
        peek(1, 1);
        chk(g_dvld == 0, "R8 queue drained", g_dvld, 0);
        do_rel(2); do_rel(1); do_rel(0);
        idle();
        chk(g_fc == NH, "R5 release after dequeue", g_fc, NH);
        for (int p = 0; p < NP; p++) phs[p].delete();

        // reserve, shared pool, limit
        cnt = 0;
        for (int i = 0; i < 7; i++) begin do_alloc(0); cnt += g_gnt; end
        chk(cnt == LIM, "R4 port limit", cnt, LIM);
        cnt = 0;
        for (int i = 0; i < 6; i++) begin do_alloc(1); cnt += g_gnt; end
        chk(cnt == LIM, "R3 shared fill", cnt, LIM);
        cnt = 0;
        for (int i = 0; i < 3; i++) begin do_alloc(2); cnt += g_gnt; end
        chk(cnt == RSV, "R3 shared exhausted", cnt, RSV);
        cnt = 0;
        for (int i = 0; i < 3; i++) begin do_alloc(3); cnt += g_gnt; end
        chk(cnt == RSV, "R3 reserve honoured", cnt, RSV);
        idle();
        chk(g_fc == 0, "R3 pool empty", g_fc, 0);
        do_rel(phs[0].pop_front());
        ha = phs[1].pop_front();
        cyc(1, 2, 1, ha, 0,0,0,0, 0,0,0);
        chk(g_gnt == 1, "R6 grant with release", g_gnt, 1);
        idle();
        chk(g_fc == 1, "R6 net free_count", g_fc, 1);

        // link and dequeue on a single-entry queue
        ha = phs[0].pop_front();
        hb = phs[0].pop_front();
        do_link(ha, 2, 0);
        cyc(0,0, 0,0, 1, hb, 2, 0, 1, 2, 0);
        chk(g_dvld && g_dh == ha, "R8 head before pair", g_dh, ha);
        peek(2, 0);
        chk(g_dvld && g_dh == hb, "R8 head after pair", g_dh, hb);
        do_deq(2, 0);
        for (int h = 0; h < NH; h++) do_rel(h);
        idle();
        chk(g_fc == NH, "R5 all returned", g_fc, NH);

        // aging disabled
        age_limit = 16'd5;
        do_alloc(1);
        seen = 0;
        for (int i = 0; i < 60; i++) begin idle(); seen += g_age; end
        chk(seen == 0, "R10 no aging when off", seen, 0);
        for (int h = 0; h < NH; h++) do_rel(h);

        // aging enabled
        age_en = 1'b1;
        age_limit = 16'd30;
        do_alloc(2);
        t0 = now - 1;
        seen = 0;
        for (int i = 0; i < 100 && !seen; i++) begin
            idle();
            if (g_age) seen = now - 1 - t0;
        end
        chk(seen > 30, "R9 reclaimed after limit", seen, 31);
        idle();
        chk(g_dc == 1 && g_fc == NH, "R9 reclaim counted", g_dc, 1);

        // random mix
        age_limit = 16'd40;
        for (int i = 0; i < 4000; i++) begin
            if (i % 700 == 0) age_en = ~age_en;
            cyc($urandom_range(0,1), $urandom_range(0,NP-1),
                $urandom_range(0,9) < 3, $urandom_range(0,NH-1),
                $urandom_range(0,3) == 0, $urandom_range(0,NH-1),
                $urandom_range(0,NP-1), $urandom_range(0,NC-1),
                $urandom_range(0,9) < 4, $urandom_range(0,NP-1), $urandom_range(0,NC-1));
        end

        done = 1;
        summary();
        $finish;
    end
endmodule